// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every data beat of a synchronous DRAM burst. A start strobe carries a starting column, a length code and an ordering bit. From the next cycle on, the block presents one beat per clock with the column that beat targets. It raises a last-beat flag on the final beat of a fixed-length burst.

Two orderings are available. Sequential ordering counts upward inside the aligned block of the burst length. Interleaved ordering XORs the beat number into the low column bits. Sequential bursts may also run in full-page mode, which walks the whole 512-column row, wraps, and only ends on a stop strobe or a new start.

A start may arrive on any clock, and it replaces the burst in progress. A stop strobe ends the burst, so no beat is presented after it. A start that asks for an unsupported combination is refused: the block pulses a reject flag and leaves the running burst alone.

Top module: `sdram_col_burst`

## Requirements
- R1: After reset, beat_valid_o, last_o and reject_o are all low.
- R2: A legal start makes beat_valid_o high in the following cycle, with col_o equal to the start column.
- R3: With ilv_i = 0 and len_code_i of 0, 1, 2 or 3 (1, 2, 4 or 8 beats), beat i shows the start column's low log2(length) bits plus i, modulo the length. The upper bits stay equal to the start column.
- R4: With ilv_i = 1 and len_code_i of 0 to 3, beat i shows the start column with its low log2(length) bits XORed with i.
- R5: len_code_i = 7 with ilv_i = 0 is a full-page burst. It increments the full column each beat, wraps from 511 to 0, runs until stopped or restarted, and never asserts last_o.
- R6: A start with len_code_i = 7 and ilv_i = 1 is refused, and so is a start with len_code_i of 4, 5 or 6. The block pulses reject_o for one cycle, and the burst state (valid, column, last) goes on as if no start had come.
- R7: last_o is high on the final beat of a fixed-length burst and only there. In the cycle after it, beat_valid_o is low unless a new start was accepted.
- R8: A legal start during a running burst discards the old burst. The next beat is beat 0 of the new burst, and this holds for starts on consecutive clocks.
- R9: stop_i without a start makes beat_valid_o low in the next cycle. If start_i and stop_i are high together, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new burst this cycle |
| start_col_i | input | COL_W (9) | Starting column |
| len_code_i | input | 3 | 0..3 = 1/2/4/8 beats, 7 = full page |
| ilv_i | input | 1 | 0 = sequential, 1 = interleaved |
| stop_i | input | 1 | Terminate the running burst |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| col_o | output | COL_W (9) | Column for the current beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| reject_o | output | 1 | Previous start was refused |

## Verification
The bench uses the default COL_W of 9, so each full-page burst covers the real 512-column row. With that width, one full-page run can be kept going for more than 512 beats. It then wraps from 511 to 0 and comes back to its start column, and the bench confirms that last_o never rises along the way. The same width lets the bench use unaligned start columns near the top of the row, where the wrap of a fixed-length sequential block must leave the upper bits unchanged. A long stretch of mixed random traffic then exercises truncation on consecutive clocks, start/stop collisions and refused requests against the behavioural model.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;
    localparam logic [2:0] LEN_1    = 3'd0;
    localparam logic [2:0] LEN_2    = 3'd1;
    localparam logic [2:0] LEN_4    = 3'd2;
    localparam logic [2:0] LEN_8    = 3'd3;
    localparam logic [2:0] LEN_PAGE = 3'd7;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;
endpackage

// File: rtl/col_burst_mode_decode.sv
module col_burst_mode_decode
    import col_burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o,
    output logic             illegal_o
);
    always_comb begin
        mask_o    = '0;
        full_o    = 1'b0;
        illegal_o = 1'b0;
        case (len_code_i)
            LEN_1:    mask_o = COL_W'(0);
            LEN_2:    mask_o = COL_W'(1);
            LEN_4:    mask_o = COL_W'(3);
            LEN_8:    mask_o = COL_W'(7);
            LEN_PAGE: begin
                mask_o    = '1;
                full_o    = 1'b1;
                illegal_o = (order_e'(ilv_i) == ORD_ILV);
            end
            default:  illegal_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/col_burst_addr_gen.sv
module col_burst_addr_gen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] idx_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] off_seq;
    logic [COL_W-1:0] off_ilv;

    always_comb begin
        off_seq = (base_i + idx_i) & mask_i;
        off_ilv = (base_i ^ idx_i) & mask_i;
        col_o   = (base_i & ~mask_i) | (ilv_i ? off_ilv : off_seq);
    end
endmodule

// File: rtl/sdram_col_burst.sv
module sdram_col_burst
    import col_burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             stop_i,
    output logic             beat_valid_o,
    output logic [COL_W-1:0] col_o,
    output logic             last_o,
    output logic             reject_o
);
    typedef struct packed {
        logic             active;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] idx;
        logic [COL_W-1:0] mask;
        logic             full;
        logic             ilv;
        logic [COL_W-1:0] col;
        logic             last;
        logic             rej;
    } state_t;

    state_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_illegal;
    logic [COL_W-1:0] idx_next;
    logic [COL_W-1:0] col_next;

    col_burst_mode_decode #(.COL_W(COL_W)) u_decode (
        .len_code_i (len_code_i),
        .ilv_i      (ilv_i),
        .mask_o     (dec_mask),
        .full_o     (dec_full),
        .illegal_o  (dec_illegal)
    );

    assign idx_next = st_q.idx + COL_W'(1);

    col_burst_addr_gen #(.COL_W(COL_W)) u_addr (
        .base_i (st_q.base),
        .idx_i  (idx_next),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ilv),
        .col_o  (col_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rej = 1'b0;
        if (start_i && dec_illegal) begin
            st_d.rej = 1'b1;
            if (st_q.active) begin
                if (stop_i || st_q.last) begin
                    st_d.active = 1'b0;
                    st_d.last   = 1'b0;
                end else begin
                    st_d.idx  = idx_next;
                    st_d.col  = col_next;
                    st_d.last = !st_q.full && (idx_next == st_q.mask);
                end
            end
        end else if (start_i) begin
            st_d.active = 1'b1;
            st_d.base   = start_col_i;
            st_d.idx    = '0;
            st_d.mask   = dec_mask;
            st_d.full   = dec_full;
            st_d.ilv    = ilv_i;
            st_d.col    = start_col_i;
            st_d.last   = !dec_full && (dec_mask == '0);
        end else if (stop_i) begin
            st_d.active = 1'b0;
            st_d.last   = 1'b0;
        end else if (st_q.active) begin
            if (st_q.last) begin
                st_d.active = 1'b0;
                st_d.last   = 1'b0;
            end else begin
                st_d.idx  = idx_next;
                st_d.col  = col_next;
                st_d.last = !st_q.full && (idx_next == st_q.mask);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_valid_o = st_q.active;
    assign col_o        = st_q.col;
    assign last_o       = st_q.last;
    assign reject_o     = st_q.rej;

    a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_valid_o);

    a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && !(start_i && !dec_illegal) |=> !beat_valid_o);

    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !dec_illegal |=> beat_valid_o && col_o == $past(start_col_i));

    a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i && !start_i |=> !beat_valid_o);

    a_r6_reject_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && dec_illegal |=> reject_o);

    a_r6_reject_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && dec_illegal && !beat_valid_o |=> !beat_valid_o);

    a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && !last_o && !stop_i && !(start_i && !dec_illegal)
        |=> beat_valid_o && ((col_o & ~st_q.mask) == ($past(col_o) & ~st_q.mask)));
endmodule

// File: tb/tb_sdram_col_burst.sv
module tb_sdram_col_burst;
    localparam int COL_W = 9;
    localparam int NCOL  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             ilv_i = 1'b0;
    logic             stop_i = 1'b0;
    logic             beat_valid_o;
    logic [COL_W-1:0] col_o;
    logic             last_o;
    logic             reject_o;

    always #5 clk = ~clk;

    sdram_col_burst #(.COL_W(COL_W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_col_i  (start_col_i),
        .len_code_i   (len_code_i),
        .ilv_i        (ilv_i),
        .stop_i       (stop_i),
        .beat_valid_o (beat_valid_o),
        .col_o        (col_o),
        .last_o       (last_o),
        .reject_o     (reject_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";

    bit m_act, m_ilv, m_full, m_rej;
    int m_base, m_i, m_len;
    int full_last_seen = 0;

    function automatic int exp_col();
        int blk, off;
        blk = m_base - (m_base % m_len);
        off = m_base % m_len;
        if (m_ilv) return blk + (off ^ m_i);
        return blk + ((off + m_i) % m_len);
    endfunction

    task automatic model_edge();
        bit illegal;
        int code;
        code = int'(len_code_i);
        illegal = (code >= 4 && code <= 6) || (code == 7 && ilv_i);
        m_rej = 1'b0;
        if (!rst_n) begin
            m_act = 0;
        end else if (start_i && illegal) begin
            m_rej = 1'b1;
            if (m_act) begin
                if (stop_i || (!m_full && m_i == m_len - 1)) m_act = 0;
                else m_i = (m_i + 1) % NCOL;
            end
        end else if (start_i) begin
            m_act  = 1;
            m_base = int'(start_col_i);
            m_i    = 0;
            m_full = (code == 7);
            m_len  = m_full ? NCOL : (1 << code);
            m_ilv  = ilv_i;
        end else if (stop_i) begin
            m_act = 0;
        end else if (m_act) begin
            if (!m_full && m_i == m_len - 1) m_act = 0;
            else m_i = (m_i + 1) % NCOL;
        end
    endtask

    task automatic compare();
        bit e_last;
        int e_col;
        e_last = m_act && !m_full && (m_i == m_len - 1);
        e_col  = m_act ? exp_col() : 0;
        n_checks++;
        if (beat_valid_o !== m_act || last_o !== e_last || reject_o !== m_rej ||
            (m_act && int'(col_o) != e_col)) begin
            n_fail++;
            $display("FAIL %s: valid/col/last/rej actual %0b/%0h/%0b/%0b expected %0b/%0h/%0b/%0b",
                     cur_req, beat_valid_o, col_o, last_o, reject_o,
                     m_act, e_col, e_last, m_rej);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (m_act && m_full && last_o) full_last_seen++;
        compare();
        start_i = 1'b0;
        stop_i  = 1'b0;
    endtask

    task automatic go(input int col, input int code, input bit ilv);
        start_i     = 1'b1;
        start_col_i = COL_W'(col);
        len_code_i  = 3'(code);
        ilv_i       = ilv;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        #(10 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        cur_req = "R1";
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R3 sequential lengths, unaligned starts
        cur_req = "R3";
        go(9'h1F6, 3, 0); idle(10);
        go(9'h0A3, 2, 0); idle(6);
        go(9'h055, 1, 0); idle(4);
        cur_req = "R7";
        go(9'h101, 0, 0); idle(3);

        // R4 interleaved
        cur_req = "R4";
        go(9'h0D5, 3, 1); idle(10);
        go(9'h1C6, 2, 1); idle(6);
        go(9'h003, 1, 1); idle(4);

        // R5 full page: wrap and revisit start, no last
        cur_req = "R5";
        go(9'h1FD, 7, 0); idle(520);
        cur_req = "R9";
        stop_i = 1'b1; step(); idle(2);
        if (full_last_seen != 0) begin
            n_fail++;
            $display("FAIL R5: last during full page actual %0d expected 0", full_last_seen);
        end
        n_checks++;

        // R6 refused requests, with and without a running burst
        cur_req = "R6";
        go(9'h040, 7, 1); step(); idle(2);
        go(9'h120, 3, 0); step(); step();
        go(9'h033, 5, 0); step(); idle(8);
        go(9'h033, 4, 1); step();
        go(9'h033, 6, 0); step(); idle(2);

        // R8 new start every clock
        cur_req = "R8";
        go(9'h010, 3, 0); step();
        go(9'h155, 2, 1); step();
        go(9'h1FF, 3, 0); step(); step();
        go(9'h0F0, 7, 0); step();
        go(9'h0F2, 1, 0); idle(4);

        // R9 stop mid burst, start wins, stop while idle
        cur_req = "R9";
        go(9'h088, 3, 0); idle(3);
        stop_i = 1'b1; step(); idle(2);
        go(9'h077, 3, 1); stop_i = 1'b1; step(); idle(3);
        stop_i = 1'b1; step(); idle(6);

        // mixed random traffic
        cur_req = "R8";
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 30) go(int'($urandom_range(0, NCOL - 1)), int'($urandom_range(0, 7)),
                           1'($urandom_range(0, 1)));
            if (r > 90) stop_i = 1'b1;
            step();
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule